// File: doc/BRIEF.md
# Multiprocessor Interrupt Controller Core

The block gathers a set of external interrupt inputs and four inter-processor interrupt channels, and routes them to a small number of CPU interrupt outputs. Each external input has its own configuration word and a destination set. The configuration word holds a mask, a sense mode (level or edge), an active polarity, a 4-bit priority and an 8-bit vector. For every CPU the core keeps a task priority and a record of the entries it has taken but not yet retired. From these it finds the best eligible request and drives that CPU's interrupt line.

Software runs the usual cycle. It reads the CPU's acknowledge register to get the vector, services the interrupt, and writes the CPU's end-of-interrupt register to retire it. Any CPU can post an inter-processor interrupt to a set of CPUs by writing a bitmask to a dispatch register. A self-clearing bit in the global configuration word returns all state to its reset values.

The register port is a single 32-bit port with separate write and read strobes. Read data is combinational from the current state. A read strobe on an acknowledge address takes effect at the next clock edge. Accesses made during a self-reset are ignored.

Top module: `opic_core`

## Requirements
- R1: After reset every source configuration word reads 0x8000_0000 (masked, priority 0), every destination reads 0, the spurious vector reads 0xFF, every task priority reads 0 and no `cpu_irq` is raised. Addresses: source s configuration at 0x100+0x10·s, its destination at 0x104+0x10·s, spurious vector at 0x008.
- R2: A source whose mask bit (bit 31 of its configuration word) is 1 is never delivered, whatever its input does.
- R3: A request reaches a CPU only if its priority (bits 19:16) is strictly greater than that CPU's task priority. The task priority sits at CPU base 0x1000+0x100·c, offset 0x00. A task priority of 15 therefore blocks everything, and priority 0 is never delivered.
- R4: A read of the acknowledge register (CPU base offset 0x10) returns the vector (bits 7:0) of the highest-priority eligible request. On equal priority an inter-processor channel beats any source, and then the lower index wins.
- R5: An acknowledge read with no eligible request returns the spurious vector and changes no state.
- R6: An acknowledge marks the chosen entry in service for that CPU. After that, only requests of strictly higher priority than any in-service entry are eligible. A write to the EOI register (offset 0x20) retires the highest-priority in-service entry.
- R7: A level source (bit 22 = 1) is pending exactly while its input equals its polarity bit (bit 23). It is delivered again after EOI if the input is still active.
- R8: An edge source (bit 22 = 0) latches a transition of its input to the polarity level. The acknowledge clears the latch. An edge that arrives while the source is in service is delivered after EOI.
- R9: Destination bit c lets CPU c take the source. When several CPUs could take it, only the lowest-numbered eligible CPU sees it.
- R10: Inter-processor channel k has its configuration word at 0x040+0x10·k. A write of CPU mask m to dispatch register CPU base offset 0x40+0x10·k, from any CPU, posts channel k to every CPU in m.
- R11: Writing a 1 to bit 31 of the global configuration word (0x004) starts a self-reset. The bit reads 1 for RST_CYCLES cycles, during which no interrupt is raised, and then reads 0 with all state at its reset values.
- R12: The feature word (0x000) reads NUM_SRC−1 in bits 26:16, NUM_CPU−1 in bits 12:8 and VERSION in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe (needed for acknowledge side effects) |
| bus_addr | input | 16 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| src_in | input | NUM_SRC | External interrupt inputs, synchronous to clk |
| cpu_irq | output | NUM_CPU | Interrupt request line for each CPU |

## Verification
The assertions assume that a write and a read strobe never coincide, so an acknowledge and an EOI for one CPU never occur in the same cycle. They also assume `src_in` is already synchronous to the clock. The bench keeps to this: each task drives exactly one strobe for one cycle and returns it to zero. Inputs change only on the falling edge, so every transition is seen as one clean edge by the latch logic.

// File: rtl/opic_pkg.sv
package opic_pkg;

    localparam int NUM_IPI = 4;

    // global registers
    localparam logic [15:0] A_FEATURE  = 16'h0000;
    localparam logic [15:0] A_GCONF    = 16'h0004;
    localparam logic [15:0] A_SPUR     = 16'h0008;
    localparam logic [15:0] A_IPI_VP   = 16'h0040;
    localparam logic [15:0] A_SRC_BASE = 16'h0100;
    localparam int          SRC_STRIDE = 16;
    localparam logic [15:0] SRC_DEST   = 16'h0004;

    // per-CPU registers
    localparam logic [15:0] A_CPU_BASE = 16'h1000;
    localparam int          CPU_STRIDE = 256;
    localparam logic [15:0] C_TASK     = 16'h0000;
    localparam logic [15:0] C_ACK      = 16'h0010;
    localparam logic [15:0] C_EOI      = 16'h0020;
    localparam logic [15:0] C_IPI      = 16'h0040;

    typedef struct packed {
        logic       mask;
        logic [6:0] rsv_hi;
        logic       pol;
        logic       level;
        logic [1:0] rsv_mid;
        logic [3:0] pri;
        logic [7:0] rsv_lo;
        logic [7:0] vec;
    } vecpri_t;

    localparam vecpri_t VP_RESET = vecpri_t'(32'h8000_0000);

    function automatic vecpri_t vp_clean(input logic [31:0] w);
        vecpri_t v;
        v         = vecpri_t'(w);
        v.rsv_hi  = '0;
        v.rsv_mid = '0;
        v.rsv_lo  = '0;
        return v;
    endfunction

endpackage

// File: rtl/opic_pick.sv
module opic_pick #(
    parameter int NE = 12,
    localparam int IW = (NE > 1) ? $clog2(NE) : 1
) (
    input  logic [NE-1:0]      req,
    input  logic [NE-1:0][3:0] pri,
    output logic               hit,
    output logic [IW-1:0]      idx,
    output logic [3:0]         top_pri
);
    // strict compare: lowest index keeps the slot on equal priority
    always_comb begin
        hit     = 1'b0;
        idx     = '0;
        top_pri = '0;
        for (int e = 0; e < NE; e++) begin
            if (req[e] && (!hit || pri[e] > top_pri)) begin
                hit     = 1'b1;
                idx     = IW'(e);
                top_pri = pri[e];
            end
        end
    end
endmodule

// File: rtl/opic_srcbank.sv
module opic_srcbank
    import opic_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int NUM_CPU = 2
) (
    input  logic                            clk,
    input  logic                            clr,
    input  logic [NUM_SRC-1:0]              vp_we,
    input  logic [NUM_SRC-1:0]              dest_we,
    input  logic [31:0]                     wdata,
    input  logic [NUM_SRC-1:0]              src_in,
    input  logic [NUM_SRC-1:0]              ack_clr,
    output vecpri_t [NUM_SRC-1:0]           vp,
    output logic [NUM_SRC-1:0][NUM_CPU-1:0] dest,
    output logic [NUM_SRC-1:0]              pend
);
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        vecpri_t              vp_q;
        logic [NUM_CPU-1:0]   dest_q;
        logic                 prev_q;
        logic                 latch_q;
        logic                 active;
        logic                 hit;

        assign active = (src_in[s] == vp_q.pol);
        assign hit    = active && (prev_q != src_in[s]) && !vp_q.level;

        always_ff @(posedge clk) begin
            if (clr) begin
                vp_q    <= VP_RESET;
                dest_q  <= '0;
                prev_q  <= 1'b0;
                latch_q <= 1'b0;
            end else begin
                if (vp_we[s])   vp_q   <= vp_clean(wdata);
                if (dest_we[s]) dest_q <= wdata[NUM_CPU-1:0];
                prev_q  <= src_in[s];
                latch_q <= hit || (latch_q && !ack_clr[s]);
            end
        end

        assign vp[s]   = vp_q;
        assign dest[s] = dest_q;
        assign pend[s] = vp_q.level ? active : latch_q;

        // R8: a transition to the active level is held until acknowledged
        assert_edge_latch_R8: assert property (@(posedge clk) disable iff (clr)
            (!vp_q.level && src_in[s] == vp_q.pol && prev_q != src_in[s]) |=> latch_q);
    end
endmodule

// File: rtl/opic_cpu.sv
module opic_cpu
    import opic_pkg::*;
#(
    parameter int NE = 12,
    localparam int IW = $clog2(NE)
) (
    input  logic               clk,
    input  logic               clr,
    input  logic               task_we,
    input  logic [3:0]         task_wdata,
    input  logic               ack,
    input  logic               eoi,
    input  logic [NUM_IPI-1:0] ipi_post,
    input  logic [NE-1:0]      req,
    input  logic [NE-1:0][3:0] pri,
    output logic [3:0]         task_pri,
    output logic [3:0]         thresh,
    output logic [NE-1:0]      insvc,
    output logic [NUM_IPI-1:0] ipi_pend,
    output logic               irq,
    output logic [IW-1:0]      sel_idx
);
    logic [3:0]   task_q;
    logic         svc_hit;
    logic [IW-1:0] svc_idx;
    logic [3:0]   svc_pri;
    logic [3:0]   sel_pri;
    logic         take;

    opic_pick #(.NE(NE)) u_svc (
        .req(insvc), .pri(pri), .hit(svc_hit), .idx(svc_idx), .top_pri(svc_pri)
    );
    opic_pick #(.NE(NE)) u_sel (
        .req(req), .pri(pri), .hit(irq), .idx(sel_idx), .top_pri(sel_pri)
    );

    assign thresh   = (task_q > svc_pri) ? task_q : svc_pri;
    assign task_pri = task_q;
    assign take     = ack && irq;

    always_ff @(posedge clk) begin
        if (clr) begin
            task_q   <= '0;
            insvc    <= '0;
            ipi_pend <= '0;
        end else begin
            if (task_we) task_q <= task_wdata;
            if (take) insvc[sel_idx] <= 1'b1;
            if (eoi && svc_hit) insvc[svc_idx] <= 1'b0;
            for (int k = 0; k < NUM_IPI; k++) begin
                ipi_pend[k] <= ipi_post[k] ||
                               (ipi_pend[k] && !(take && sel_idx == IW'(k)));
            end
        end
    end

    assert_task_gate_R3: assert property (@(posedge clk) disable iff (clr)
        irq |-> (sel_pri > task_q));
    assert_full_block_R3: assert property (@(posedge clk) disable iff (clr)
        (task_q == 4'hF) |-> !irq);
    assert_ack_marks_R6: assert property (@(posedge clk) disable iff (clr)
        take |=> insvc[$past(sel_idx)]);
    assert_eoi_retire_R6: assert property (@(posedge clk) disable iff (clr)
        (eoi && svc_hit && !ack) |=> ($countones(insvc) == $countones($past(insvc)) - 1));
endmodule

// File: rtl/opic_core.sv
module opic_core
    import opic_pkg::*;
#(
    parameter int NUM_SRC    = 8,
    parameter int NUM_CPU    = 2,
    parameter int RST_CYCLES = 4,
    parameter int VERSION    = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_we,
    input  logic               bus_re,
    input  logic [15:0]        bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_SRC-1:0] src_in,
    output logic [NUM_CPU-1:0] cpu_irq
);
    localparam int NE = NUM_IPI + NUM_SRC;
    localparam int IW = $clog2(NE);
    localparam int CW = $clog2(RST_CYCLES + 1);

    logic [CW-1:0] soft_cnt;
    logic          soft_busy;
    logic          clr;
    logic [7:0]    spur_q;
    vecpri_t [NUM_IPI-1:0] ipi_vp;

    // decode strobes
    logic [NUM_SRC-1:0]              vp_we, dest_we, ack_clr;
    logic [NUM_IPI-1:0]              ipi_vp_we;
    logic [NUM_CPU-1:0]              task_we, ack, eoi;
    logic [NUM_CPU-1:0][NUM_IPI-1:0] ipi_post;
    logic                            spur_we, gconf_we;

    // source and CPU state
    vecpri_t [NUM_SRC-1:0]              vp;
    logic [NUM_SRC-1:0][NUM_CPU-1:0]    dest;
    logic [NUM_SRC-1:0]                 pend;
    vecpri_t [NE-1:0]                   vp_all;
    logic [NE-1:0][3:0]                 pri_all;
    logic [NUM_CPU-1:0][3:0]            task_pri, thresh;
    logic [NUM_CPU-1:0][NE-1:0]         insvc, cand, req;
    logic [NUM_CPU-1:0][NUM_IPI-1:0]    ipi_pend;
    logic [NUM_CPU-1:0][IW-1:0]         sel_idx;

    assign soft_busy = (soft_cnt != '0);
    assign clr       = rst || soft_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            soft_cnt <= '0;
        end else if (soft_busy) begin
            soft_cnt <= soft_cnt - 1'b1;
        end else if (gconf_we && bus_wdata[31]) begin
            soft_cnt <= CW'(RST_CYCLES);
        end
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            spur_q <= 8'hFF;
            ipi_vp <= {NUM_IPI{VP_RESET}};
        end else begin
            if (spur_we) spur_q <= bus_wdata[7:0];
            for (int k = 0; k < NUM_IPI; k++)
                if (ipi_vp_we[k]) ipi_vp[k] <= vp_clean(bus_wdata);
        end
    end

    // address decode, ignored during self-reset
    always_comb begin
        vp_we = '0; dest_we = '0; ipi_vp_we = '0;
        task_we = '0; ack = '0; eoi = '0; ipi_post = '0;
        spur_we = 1'b0; gconf_we = 1'b0;
        if (!soft_busy) begin
            spur_we  = bus_we && bus_addr == A_SPUR;
            gconf_we = bus_we && bus_addr == A_GCONF;
            for (int s = 0; s < NUM_SRC; s++) begin
                vp_we[s]   = bus_we && bus_addr == A_SRC_BASE + 16'(s * SRC_STRIDE);
                dest_we[s] = bus_we && bus_addr == A_SRC_BASE + 16'(s * SRC_STRIDE) + SRC_DEST;
            end
            for (int k = 0; k < NUM_IPI; k++)
                ipi_vp_we[k] = bus_we && bus_addr == A_IPI_VP + 16'(k * 16);
            for (int c = 0; c < NUM_CPU; c++) begin
                task_we[c] = bus_we && bus_addr == A_CPU_BASE + 16'(c * CPU_STRIDE) + C_TASK;
                ack[c]     = bus_re && bus_addr == A_CPU_BASE + 16'(c * CPU_STRIDE) + C_ACK;
                eoi[c]     = bus_we && bus_addr == A_CPU_BASE + 16'(c * CPU_STRIDE) + C_EOI;
                for (int k = 0; k < NUM_IPI; k++) begin
                    if (bus_we && bus_addr == A_CPU_BASE + 16'(c * CPU_STRIDE) + C_IPI + 16'(k * 16)) begin
                        for (int d = 0; d < NUM_CPU; d++)
                            ipi_post[d][k] = ipi_post[d][k] | bus_wdata[d];
                    end
                end
            end
        end
    end

    opic_srcbank #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_src (
        .clk(clk), .clr(clr), .vp_we(vp_we), .dest_we(dest_we), .wdata(bus_wdata),
        .src_in(src_in), .ack_clr(ack_clr), .vp(vp), .dest(dest), .pend(pend)
    );

    // entry table: channels first, so they win ties
    always_comb begin
        for (int k = 0; k < NUM_IPI; k++) vp_all[k] = ipi_vp[k];
        for (int s = 0; s < NUM_SRC; s++) vp_all[NUM_IPI + s] = vp[s];
        for (int e = 0; e < NE; e++) pri_all[e] = vp_all[e].pri;
    end

    // eligibility and steering of shared sources to the lowest CPU
    logic busy_any;
    logic taken;
    always_comb begin
        cand = '0;
        req  = '0;
        for (int c = 0; c < NUM_CPU; c++)
            for (int k = 0; k < NUM_IPI; k++)
                cand[c][k] = ipi_pend[c][k] && !ipi_vp[k].mask && !insvc[c][k] &&
                             ipi_vp[k].pri > thresh[c];
        for (int s = 0; s < NUM_SRC; s++) begin
            busy_any = 1'b0;
            for (int c = 0; c < NUM_CPU; c++) busy_any = busy_any | insvc[c][NUM_IPI + s];
            for (int c = 0; c < NUM_CPU; c++)
                cand[c][NUM_IPI + s] = pend[s] && !vp[s].mask && dest[s][c] && !busy_any &&
                                       vp[s].pri > thresh[c];
        end
        for (int k = 0; k < NUM_IPI; k++)
            for (int c = 0; c < NUM_CPU; c++) req[c][k] = cand[c][k];
        taken = 1'b0;
        for (int s = 0; s < NUM_SRC; s++) begin
            taken = 1'b0;
            for (int c = 0; c < NUM_CPU; c++) begin
                req[c][NUM_IPI + s] = cand[c][NUM_IPI + s] && !taken;
                taken = taken | cand[c][NUM_IPI + s];
            end
        end
    end

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        opic_cpu #(.NE(NE)) u_cpu (
            .clk(clk), .clr(clr), .task_we(task_we[c]), .task_wdata(bus_wdata[3:0]),
            .ack(ack[c]), .eoi(eoi[c]), .ipi_post(ipi_post[c]), .req(req[c]),
            .pri(pri_all), .task_pri(task_pri[c]), .thresh(thresh[c]),
            .insvc(insvc[c]), .ipi_pend(ipi_pend[c]), .irq(cpu_irq[c]),
            .sel_idx(sel_idx[c])
        );
    end

    // acknowledge clears the edge latch of the source it hands out
    always_comb begin
        ack_clr = '0;
        for (int c = 0; c < NUM_CPU; c++)
            for (int s = 0; s < NUM_SRC; s++)
                if (ack[c] && cpu_irq[c] && sel_idx[c] == IW'(NUM_IPI + s))
                    ack_clr[s] = 1'b1;
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_FEATURE)
            bus_rdata = {5'b0, 11'(NUM_SRC - 1), 3'b0, 5'(NUM_CPU - 1), 8'(VERSION)};
        if (bus_addr == A_GCONF) bus_rdata = {soft_busy, 31'b0};
        if (bus_addr == A_SPUR)  bus_rdata = {24'b0, spur_q};
        for (int k = 0; k < NUM_IPI; k++)
            if (bus_addr == A_IPI_VP + 16'(k * 16)) bus_rdata = ipi_vp[k];
        for (int s = 0; s < NUM_SRC; s++) begin
            if (bus_addr == A_SRC_BASE + 16'(s * SRC_STRIDE)) bus_rdata = vp[s];
            if (bus_addr == A_SRC_BASE + 16'(s * SRC_STRIDE) + SRC_DEST)
                bus_rdata = 32'(dest[s]);
        end
        for (int c = 0; c < NUM_CPU; c++) begin
            if (bus_addr == A_CPU_BASE + 16'(c * CPU_STRIDE) + C_TASK)
                bus_rdata = {28'b0, task_pri[c]};
            if (bus_addr == A_CPU_BASE + 16'(c * CPU_STRIDE) + C_ACK)
                bus_rdata = {24'b0, cpu_irq[c] ? vp_all[sel_idx[c]].vec : spur_q};
        end
    end

    assert_soft_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        (soft_busy && $past(soft_busy)) |-> (cpu_irq == '0));
endmodule

// File: tb/tb_opic_core.sv
module tb_opic_core;
    localparam int NS = 8;
    localparam int NC = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_we = 1'b0;
    logic          bus_re = 1'b0;
    logic [15:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NS-1:0] src_in = '0;
    logic [NC-1:0] cpu_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    opic_core #(.NUM_SRC(NS), .NUM_CPU(NC), .RST_CYCLES(4), .VERSION(2)) dut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in), .cpu_irq(cpu_irq)
    );

    function automatic logic [15:0] a_src(int s);  return 16'(16'h100 + 16 * s);            endfunction
    function automatic logic [15:0] a_cpu(int c, int off); return 16'(16'h1000 + 256 * c + off); endfunction
    function automatic logic [31:0] vpw(bit m, bit lvl, bit pol, int p, int v);
        return {m, 7'b0, pol, lvl, 2'b0, 4'(p), 8'b0, 8'(v)};
    endfunction
    function automatic int pri_of(int s); return (s * 3) % 5 + 2; endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [15:0] a, logic [31:0] d);
        @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_we = 1'b0;
    endtask

    task automatic rd(logic [15:0] a, output logic [31:0] d);
        @(negedge clk); bus_re = 1'b1; bus_addr = a; #1 d = bus_rdata;
        @(negedge clk); bus_re = 1'b0;
    endtask

    task automatic settle(); @(negedge clk); #1; endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        int best, bp;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        settle();

        // R1: reset state
        rd(a_src(0), d);            check("R1 src0 cfg", d, 32'h8000_0000);
        rd(a_src(NS - 1), d);       check("R1 src7 cfg", d, 32'h8000_0000);
        rd(a_src(3) + 16'h4, d);    check("R1 dest", d, 0);
        rd(16'h0008, d);            check("R1 spurious", d, 32'hFF);
        rd(a_cpu(1, 0), d);         check("R1 task", d, 0);
        check("R1 irq", 32'(cpu_irq), 0);

        // R12: feature word
        rd(16'h0000, d); check("R12 feature", d, {5'b0, 11'(NS - 1), 3'b0, 5'(NC - 1), 8'd2});

        // R5: no request gives spurious vector
        wr(16'h0008, 32'h7E);
        rd(a_cpu(0, 16'h10), d); check("R5 spurious ack", d, 32'h7E);

        // R2: masked source with active input
        wr(a_src(0), vpw(1, 1, 1, 9, 8'h20));
        wr(a_src(0) + 16'h4, 1);
        src_in[0] = 1'b1; settle();
        check("R2 masked irq", 32'(cpu_irq), 0);
        rd(a_cpu(0, 16'h10), d); check("R2 masked ack", d, 32'h7E);

        // R3: sweep task priority against source priority
        for (int t = 0; t < 16; t++) begin
            wr(a_cpu(0, 0), t);
            for (int p = 1; p < 16; p++) begin
                wr(a_src(0), vpw(0, 1, 1, p, 8'h20));
                settle();
                check($sformatf("R3 t%0d p%0d", t, p), 32'(cpu_irq[0]), (p > t) ? 1 : 0);
            end
        end
        wr(a_src(0), vpw(0, 1, 1, 0, 8'h20));
        wr(a_cpu(0, 0), 0); settle();
        check("R3 prio zero", 32'(cpu_irq[0]), 0);
        src_in = '0;

        // R4/R6: arbitration over every input pattern
        for (int s = 0; s < NS; s++) begin
            wr(a_src(s), vpw(0, 1, 1, pri_of(s), 8'h20 + s));
            wr(a_src(s) + 16'h4, 1);
        end
        for (int pat = 1; pat < 256; pat++) begin
            best = -1; bp = 0;
            for (int s = 0; s < NS; s++)
                if (pat[s] && pri_of(s) > bp) begin best = s; bp = pri_of(s); end
            @(negedge clk); src_in = 8'(pat);
            rd(a_cpu(0, 16'h10), d); check($sformatf("R4 pat %0d", pat), d, 32'h20 + best);
            rd(a_cpu(0, 16'h10), d); check($sformatf("R6 no equal %0d", pat), d, 32'h7E);
            @(negedge clk); src_in = '0;
            wr(a_cpu(0, 16'h20), 0);
        end

        // R6: nesting and EOI order
        @(negedge clk); src_in[2] = 1'b1;
        rd(a_cpu(0, 16'h10), d); check("R6 first", d, 32'h22);
        @(negedge clk); src_in[0] = 1'b1; settle();
        check("R6 lower blocked", 32'(cpu_irq[0]), 0);
        @(negedge clk); src_in[3] = 1'b1; settle();
        check("R6 higher preempts", 32'(cpu_irq[0]), 1);
        rd(a_cpu(0, 16'h10), d); check("R6 nested", d, 32'h23);
        @(negedge clk); src_in = '0;
        wr(a_cpu(0, 16'h20), 0);
        @(negedge clk); src_in[1] = 1'b1; settle();
        check("R6 eoi retired top", 32'(cpu_irq[0]), 1);
        rd(a_cpu(0, 16'h10), d); check("R6 after eoi", d, 32'h21);
        @(negedge clk); src_in = '0;
        wr(a_cpu(0, 16'h20), 0);
        wr(a_cpu(0, 16'h20), 0); settle();
        check("R6 all retired", 32'(cpu_irq[0]), 0);
        for (int s = 0; s < NS; s++) wr(a_src(s), vpw(1, 1, 1, 1, 0));

        // R7: active-low level source
        @(negedge clk); src_in[4] = 1'b1;
        wr(a_src(4), vpw(0, 1, 0, 6, 8'h24)); settle();
        check("R7 inactive", 32'(cpu_irq[0]), 0);
        @(negedge clk); src_in[4] = 1'b0; settle();
        check("R7 active", 32'(cpu_irq[0]), 1);
        rd(a_cpu(0, 16'h10), d); check("R7 vector", d, 32'h24);
        wr(a_cpu(0, 16'h20), 0); settle();
        check("R7 still active", 32'(cpu_irq[0]), 1);
        @(negedge clk); src_in[4] = 1'b1; settle();
        check("R7 released", 32'(cpu_irq[0]), 0);
        wr(a_src(4), vpw(1, 1, 0, 6, 8'h24));
        @(negedge clk); src_in[4] = 1'b0;

        // R8: edge latch
        wr(a_src(5), vpw(0, 0, 1, 2, 8'h25));
        @(negedge clk); src_in[5] = 1'b1;
        @(negedge clk); src_in[5] = 1'b0; settle();
        check("R8 latched", 32'(cpu_irq[0]), 1);
        rd(a_cpu(0, 16'h10), d); check("R8 vector", d, 32'h25);
        settle(); check("R8 ack clears", 32'(cpu_irq[0]), 0);
        @(negedge clk); src_in[5] = 1'b1;
        @(negedge clk); src_in[5] = 1'b0; settle();
        check("R8 held in service", 32'(cpu_irq[0]), 0);
        wr(a_cpu(0, 16'h20), 0); settle();
        check("R8 after eoi", 32'(cpu_irq[0]), 1);
        rd(a_cpu(0, 16'h10), d); check("R8 second", d, 32'h25);
        wr(a_cpu(0, 16'h20), 0); settle();
        check("R8 drained", 32'(cpu_irq[0]), 0);
        wr(a_src(5), vpw(1, 0, 1, 2, 8'h25));

        // R9: destination steering
        wr(a_src(6), vpw(0, 1, 1, 5, 8'h26));
        wr(a_src(6) + 16'h4, 3);
        @(negedge clk); src_in[6] = 1'b1; settle();
        check("R9 lowest cpu", 32'(cpu_irq), 32'b01);
        wr(a_cpu(0, 0), 15); settle();
        check("R9 next cpu", 32'(cpu_irq), 32'b10);
        rd(a_cpu(1, 16'h10), d); check("R9 cpu1 ack", d, 32'h26);
        @(negedge clk); src_in[6] = 1'b0;
        wr(a_cpu(1, 16'h20), 0);
        wr(a_cpu(0, 0), 0);
        wr(a_src(6) + 16'h4, 2);
        @(negedge clk); src_in[6] = 1'b1; settle();
        check("R9 dest only cpu1", 32'(cpu_irq), 32'b10);
        @(negedge clk); src_in[6] = 1'b0;
        wr(a_src(6), vpw(1, 1, 1, 5, 8'h26));

        // R10: inter-processor dispatch, R4 tie with a source
        wr(16'h0060, vpw(0, 0, 0, 7, 8'h42));
        wr(a_src(0), vpw(0, 1, 1, 7, 8'h20));
        wr(a_src(0) + 16'h4, 1);
        @(negedge clk); src_in[0] = 1'b1;
        wr(a_cpu(1, 16'h60), 3); settle();
        check("R10 both raised", 32'(cpu_irq), 32'b11);
        rd(a_cpu(0, 16'h10), d); check("R10 R4 tie cpu0", d, 32'h42);
        rd(a_cpu(1, 16'h10), d); check("R10 cpu1", d, 32'h42);
        settle(); check("R10 equal blocked", 32'(cpu_irq), 0);
        wr(a_cpu(0, 16'h20), 0); settle();
        check("R10 source after eoi", 32'(cpu_irq), 32'b01);
        rd(a_cpu(0, 16'h10), d); check("R10 source vec", d, 32'h20);
        @(negedge clk); src_in = '0;
        wr(a_cpu(0, 16'h20), 0);
        wr(a_cpu(1, 16'h20), 0);

        // R11: self-reset
        @(negedge clk); src_in[0] = 1'b1; settle();
        check("R11 pre irq", 32'(cpu_irq), 32'b01);
        wr(16'h0004, 32'h8000_0000);
        rd(16'h0004, d); check("R11 busy", d, 32'h8000_0000);
        check("R11 quiet", 32'(cpu_irq), 0);
        repeat (6) @(negedge clk);
        rd(16'h0004, d); check("R11 cleared", d, 0);
        rd(a_src(0), d); check("R11 cfg reset", d, 32'h8000_0000);
        rd(16'h0008, d); check("R11 spurious reset", d, 32'hFF);
        check("R11 irq low", 32'(cpu_irq), 0);

        finish_run();
    end
endmodule